// File: doc/BRIEF.md
# Dual Tick Timer (One-Shot and Auto-Reload)

This block holds two 32-bit tick timers behind one small register window. Both timers count an external tick-enable input rather than raw clock cycles, so the tick rate is set outside the block. Timer 0 is a one-shot. It raises a single interrupt pulse when its programmed interval has elapsed and then returns to idle with its interval cleared. Timer 1 is auto-reloading. It pulses its interrupt each time the interval elapses and then starts the same interval again.

Software arms a timer by writing a nonzero interval to the timer's control word. Any such write throws away the count in progress and restarts from that cycle. Writing zero stops the timer. Each timer also has a read-only remaining word that reports how many ticks are left before the next expiry. Register values are carried big-endian: the byte at the lowest address of a word is the most significant byte. Only full 4-byte accesses are legal. Any other access size raises a sticky error flag and changes nothing else.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset, both intervals and both remaining counts read 0, both interrupt outputs are low and `size_err` is low.
- R2: A 4-byte write of a nonzero value V to offset 0x20 (one-shot) or 0x28 (auto-reload) sets that timer's interval and remaining count to V. It cancels any count in progress. A read of the same offset returns the interval.
- R3: A 4-byte write of zero to offset 0x20 or 0x28 sets that timer's interval and remaining count to 0. The timer then raises no interrupt.
- R4: On each cycle with `tick_en` high, a timer whose remaining count is above 1 decrements it by one. Without `tick_en` the count holds. Offsets 0x24 (one-shot) and 0x2C (auto-reload) read the remaining count, which is 0 while the timer is idle.
- R5: On a tick where the one-shot's remaining count is 1, `irq_oneshot` is high for exactly the next cycle, and the one-shot's interval and remaining count both become 0.
- R6: On a tick where the auto-reload timer's remaining count is 1, `irq_periodic` is high for the next cycle, and the remaining count is reloaded with the interval. The timer keeps counting after the reload.
- R7: Data is big-endian. Bus bits [8*k+7:8*k] carry the byte at address offset k, so bits [7:0] hold the most significant byte of the register value.
- R8: An access with `bus_size` not equal to 4 to any aligned offset in 0x20..0x2F sets `size_err`, which stays set until reset. The access changes no timer state, and a read returns 0.
- R9: Writes to the remaining offsets are ignored. Reads of offsets outside 0x20..0x2F, or with `bus_addr[1:0]` not zero, return 0, and writes to them are ignored.
- R10: When a control write and a tick fall in the same cycle, the write takes effect and the tick does not count or expire.
- R11: Every read request is answered one cycle later with `bus_rvalid` high. `bus_rdata` then holds the register value as it was before the request cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One timer tick per cycle while high |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the block |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data, byte lane k = address offset k |
| bus_rdata | output | 32 | Read data, same lane order |
| bus_rvalid | output | 1 | Read data valid (one cycle after the request) |
| size_err | output | 1 | Sticky flag for an access of the wrong size |
| irq_oneshot | output | 1 | One-shot expiry pulse |
| irq_periodic | output | 1 | Auto-reload expiry pulse |

## Verification
Directed intervals of 1, 2 and 3 ticks are used with the tick held high. They show whether expiry lands on the count of 1 or one tick late, and whether the auto-reload fires on every tick when the interval is 1. Writes are placed in the same cycle as ticks, during running counts and just before an expiry, to separate write-wins restart from decrement. Accesses of sizes 1, 2 and 3 to every register show whether an illegal access leaks into the timer state. A long random phase mixes sparse and dense ticks, short intervals, reads and stray offsets, and compares every cycle against a bench model.

// File: rtl/ttp_pkg.sv
package ttp_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 32;
    localparam int SIZE_W     = 3;
    localparam int NUM_TIMERS = 2;
    localparam int IDX_W      = $clog2(NUM_TIMERS);
    localparam int FULL_SIZE  = DATA_W / 8;

    // window occupies offsets 0x20..0x2F: addr[5:4] == 2'b10
    localparam logic [1:0] WIN_TAG = 2'b10;

    typedef enum logic [0:0] {
        FIELD_INTERVAL  = 1'b0,
        FIELD_REMAINING = 1'b1
    } field_e;

    typedef struct packed {
        logic            hit;
        logic            bad_size;
        logic [IDX_W-1:0] idx;
        field_e          field;
    } dec_t;

    function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int k = 0; k < DATA_W / 8; k++) begin
            r[8*k +: 8] = v[DATA_W - 8*(k+1) +: 8];
        end
        return r;
    endfunction

    function automatic bit timer_reloads(input int i);
        return i == 1;
    endfunction

endpackage

// File: rtl/ttp_decode.sv
module ttp_decode
    import ttp_pkg::*;
(
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output dec_t              dec
);

    always_comb begin
        dec          = '0;
        dec.hit      = valid && (addr[ADDR_W-1:4] == WIN_TAG) && (addr[1:0] == 2'b00);
        dec.bad_size = dec.hit && (size != SIZE_W'(FULL_SIZE));
        dec.idx      = addr[3 +: IDX_W];
        dec.field    = field_e'(addr[2]);
    end

endmodule

// File: rtl/ttp_counter.sv
module ttp_counter #(
    parameter int CNT_W       = 32,
    parameter bit AUTO_RELOAD = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] remaining,
    output logic             fire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            interval  <= '0;
            remaining <= '0;
            fire      <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                interval  <= load_val;
                remaining <= load_val;
            end else if (tick && remaining != '0) begin
                if (remaining == ONE) begin
                    fire <= 1'b1;
                    if (AUTO_RELOAD) begin
                        remaining <= interval;
                    end else begin
                        remaining <= '0;
                        interval  <= '0;
                    end
                end else begin
                    remaining <= remaining - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
    import ttp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              size_err,
    output logic              irq_oneshot,
    output logic              irq_periodic
);

    dec_t dec;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_ivl;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_rem;
    logic [NUM_TIMERS-1:0]             cnt_fire;
    logic [DATA_W-1:0]                 wr_value;

    assign wr_value = lane_swap(bus_wdata);

    ttp_decode u_dec (
        .valid (bus_valid),
        .addr  (bus_addr),
        .size  (bus_size),
        .dec   (dec)
    );

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        logic ld;
        assign ld = bus_write && dec.hit && !dec.bad_size
                    && (dec.field == FIELD_INTERVAL) && (dec.idx == IDX_W'(i));
        ttp_counter #(
            .CNT_W       (DATA_W),
            .AUTO_RELOAD (timer_reloads(i))
        ) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick_en),
            .load      (ld),
            .load_val  (wr_value),
            .interval  (cnt_ivl[i]),
            .remaining (cnt_rem[i]),
            .fire      (cnt_fire[i])
        );
    end

    assign irq_oneshot  = cnt_fire[0];
    assign irq_periodic = cnt_fire[1];

    logic [DATA_W-1:0] rd_sel;
    always_comb begin
        rd_sel = '0;
        if (dec.hit && !dec.bad_size) begin
            rd_sel = (dec.field == FIELD_REMAINING) ? cnt_rem[dec.idx] : cnt_ivl[dec.idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            size_err   <= 1'b0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            bus_rdata  <= (bus_valid && !bus_write) ? lane_swap(rd_sel) : '0;
            if (dec.bad_size) begin
                size_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ttp_checker.sv
module ttp_checker
    import ttp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [SIZE_W-1:0] bus_size,
    input logic              size_err,
    input logic              irq_oneshot,
    input logic              irq_periodic,
    input logic [DATA_W-1:0] ivl0,
    input logic [DATA_W-1:0] rem0,
    input logic [DATA_W-1:0] ivl1,
    input logic [DATA_W-1:0] rem1
);

    logic bad_req;
    assign bad_req = bus_valid && bus_addr[5:4] == 2'b10 && bus_addr[1:0] == 2'b00
                     && bus_size != SIZE_W'(FULL_SIZE);

    assert_oneshot_single_R5: assert property (@(posedge clk) disable iff (rst)
        irq_oneshot |=> !irq_oneshot);

    assert_oneshot_clears_R5: assert property (@(posedge clk) disable iff (rst)
        irq_oneshot |-> (ivl0 == '0 && rem0 == '0));

    assert_expiry_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_oneshot || irq_periodic) |-> $past(tick_en));

    assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (rst)
        irq_periodic |-> (rem1 == ivl1 && ivl1 != '0));

    assert_remaining_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        (rem0 <= ivl0) && (rem1 <= ivl1));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        size_err |=> size_err);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(size_err) |-> $past(bad_req));

endmodule

bind tick_timer_pair ttp_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .bus_valid    (bus_valid),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .size_err     (size_err),
    .irq_oneshot  (irq_oneshot),
    .irq_periodic (irq_periodic),
    .ivl0         (cnt_ivl[0]),
    .rem0         (cnt_rem[0]),
    .ivl1         (cnt_ivl[1]),
    .rem1         (cnt_rem[1])
);

// File: tb/tick_timer_pair_test.sv
module tick_timer_pair_test;
    import ttp_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              tick_en;
    logic              bus_valid;
    logic              bus_write;
    logic [ADDR_W-1:0] bus_addr;
    logic [SIZE_W-1:0] bus_size;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_rvalid;
    logic              size_err;
    logic              irq_oneshot;
    logic              irq_periodic;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model, values in register (not bus) order
    logic [31:0] m_ivl [2];
    logic [31:0] m_rem [2];
    bit          m_err;

    always #4 clk = ~clk;

    tick_timer_pair uut (.*);

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_ivl[i] = 0;
            m_rem[i] = 0;
        end
        m_err = 0;
    endtask

    // one clock cycle with the given request; returns bus-order read data seen
    task automatic step(input bit v, input bit w, input logic [5:0] a, input logic [2:0] sz,
                        input logic [31:0] value, input bit tk);
        bit hit, ok, fire [2];
        logic [31:0] exp_rd;
        int t;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz;
        bus_wdata = bswap(value); tick_en = tk;
        hit = v && a[5:4] == 2'b10 && a[1:0] == 2'b00;
        ok  = hit && sz == 3'd4;
        t   = a[3];
        exp_rd = 0;
        if (ok && !w) exp_rd = a[2] ? m_rem[t] : m_ivl[t];
        if (hit && sz != 3'd4) m_err = 1;
        for (int i = 0; i < 2; i++) begin
            fire[i] = 0;
            if (ok && w && !a[2] && t == i) begin
                m_ivl[i] = value; m_rem[i] = value;
            end else if (tk && m_rem[i] != 0) begin
                if (m_rem[i] == 1) begin
                    fire[i] = 1;
                    if (i == 1) m_rem[i] = m_ivl[i];
                    else begin m_rem[i] = 0; m_ivl[i] = 0; end
                end else m_rem[i] = m_rem[i] - 1;
            end
        end
        @(posedge clk); #1;
        chk("R5 irq_oneshot", 32'(irq_oneshot), 32'(fire[0]));
        chk("R6 irq_periodic", 32'(irq_periodic), 32'(fire[1]));
        chk("R8 size_err", 32'(size_err), 32'(m_err));
        chk("R11 rvalid", 32'(bus_rvalid), 32'(v && !w));
        if (v && !w) chk("R2/R4/R7/R9 rdata", bus_rdata, bswap(exp_rd));
    endtask

    task automatic idle(input bit tk);
        step(0, 0, 0, 4, 0, tk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] value, input bit tk);
        step(1, 1, a, 4, value, tk);
    endtask

    task automatic rd(input logic [5:0] a);
        step(1, 0, a, 4, 0, 0);
    endtask

    initial begin
        int wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", wd);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        rst = 1; tick_en = 0; bus_valid = 0; bus_write = 0;
        bus_addr = 0; bus_size = 4; bus_wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        chk("R1 irq_oneshot", 32'(irq_oneshot), 0);
        chk("R1 irq_periodic", 32'(irq_periodic), 0);
        chk("R1 size_err", 32'(size_err), 0);
        for (int o = 0; o < 4; o++) rd(6'h20 + 6'(4*o));

        // R7 lane order: bus bits [7:0] carry MSB
        step(1, 1, 6'h20, 4, 32'h01020304, 0);
        chk("R7 bus lane", bus_wdata, 32'h04030201);
        step(1, 0, 6'h20, 4, 0, 0);
        chk("R7 read lane", bus_rdata, 32'h04030201);

        // R2/R5 one-shot of 3 with steady ticks
        wr(6'h20, 3, 0);
        repeat (5) idle(1);
        rd(6'h20);
        chk("R5 interval cleared", bus_rdata, 0);
        rd(6'h24);
        chk("R5 remaining idle", bus_rdata, 0);

        // R6 periodic of 1 fires every tick, of 2 every other
        wr(6'h28, 1, 0);
        repeat (4) idle(1);
        wr(6'h28, 2, 0);
        repeat (6) idle(1);
        rd(6'h28);
        chk("R6 interval kept", bus_rdata, bswap(2));

        // R4 no tick, no change
        wr(6'h20, 10, 0);
        repeat (3) idle(0);
        rd(6'h24);
        chk("R4 hold", bus_rdata, bswap(10));

        // R10 write with tick restarts; R2 rewrite during count
        idle(1); idle(1);
        wr(6'h20, 2, 1);
        rd(6'h24);
        chk("R10 write wins", bus_rdata, bswap(2));
        idle(1);
        wr(6'h20, 5, 1);       // would have expired here
        chk("R10 no expiry", 32'(irq_oneshot), 0);

        // R3 write zero stops
        wr(6'h28, 0, 0);
        wr(6'h20, 0, 0);
        repeat (6) idle(1);
        rd(6'h2C);
        chk("R3 stopped", bus_rdata, 0);

        // R9 write to remaining ignored, stray offsets read 0
        wr(6'h20, 7, 0);
        wr(6'h24, 1, 0);
        rd(6'h24);
        chk("R9 remaining write ignored", bus_rdata, bswap(7));
        wr(6'h21, 9, 0);
        rd(6'h20);
        chk("R9 misaligned ignored", bus_rdata, bswap(7));
        rd(6'h10); rd(6'h30);

        // R8 bad sizes
        for (int s = 1; s < 4; s++) begin
            step(1, 1, 6'h20, 3'(s), 99, 0);
            step(1, 0, 6'h24, 3'(s), 0, 0);
            chk("R8 bad read zero", bus_rdata, 0);
        end
        rd(6'h20);
        chk("R8 interval untouched", bus_rdata, bswap(7));
        chk("R8 sticky", 32'(size_err), 1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [5:0] a;
            logic [2:0] sz;
            r  = $urandom_range(0, 99);
            a  = (r < 80) ? 6'(6'h20 + 4 * $urandom_range(0, 3)) : 6'($urandom_range(0, 63));
            sz = ($urandom_range(0, 19) == 0) ? 3'($urandom_range(0, 7)) : 3'd4;
            step($urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0, a, sz,
                 32'($urandom_range(0, 9)), (n % 500 < 250) ? $urandom_range(0, 1) == 1
                                                            : $urandom_range(0, 9) != 0);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule